// File: doc/BRIEF.md
# Bus-Snooping Scanline Interrupt Counter

This block works out which video line is being drawn without any access to the video processor's internal state. It only watches the processor's memory read strobe and address. At the start of each visible line the video processor reads the same nametable byte three times in a row. The block detects that pattern and uses it to mark a new line. The first mark after the frame was left means the frame has been entered, and the line count starts at zero. Each later mark adds one to the count. When the count reaches a target written by software, an interrupt becomes pending.

The block also has to notice that a frame is over, because the video bus gives no explicit signal for this. Three things take the block out of the frame:

- an interrupt vector fetch by the CPU;
- a CPU write that turns off both background and sprite rendering;
- three CPU cycles in which the video bus makes no read at all.

The same per-line fetch counter also drives the choice of pattern bank set when tall (8×16) sprites are enabled. The counter counts pattern-table reads after each line mark. At one fetch number it switches to the sprite bank set, and at a later fetch number it switches back to the background set.

Top module: `scan_snoop_top`

## Requirements
- R1: A video read in 0x2000–0x3EFF whose low 10 bits are below 0x3C0, at the same address as the previous read in that range, advances a match count. Any other read in that range clears the count. The third identical read in a row marks a line. Further repeats of the same address do not mark again. Reads below 0x2000 leave the match state alone.
- R2: Reads in the nametable range whose low 10 bits are 0x3C0 or above (attribute reads) never mark a line.
- R3: A line mark outside the frame sets in-frame and loads a line count of zero. A line mark inside the frame adds one to the count. If the new count equals the 8-bit target written at CPU address 0x5203, the pending flag is set.
- R4: With a target of 0, no number of line marks within a frame sets the pending flag.
- R5: A CPU read of 0x5204 returns pending in bit 7 and in-frame in bit 6, with the other bits 0. The read clears pending. If a line mark sets pending in the same cycle, the set wins. A CPU read of any other address returns 0.
- R6: A CPU write to 0x5204 loads the interrupt enable from data bit 7. `irq_o` is high when pending and enable are both high. Pending is kept while the enable is low.
- R7: A CPU read of 0xFFFA or 0xFFFB clears in-frame and the stored previous address.
- R8: A CPU write to 0x2001 with data bits 4 and 3 both 0 clears in-frame and the stored previous address. A write to 0x2001 with either of those bits set has no effect.
- R9: Three consecutive asserted `cpu_ce` cycles with no video read in the span they cover clear in-frame and the stored previous address. Two such cycles do not.
- R10: The tall-sprite flag is loaded from data bit 5 of CPU writes to 0x2000. While the flag is set, the pattern-table read (address below 0x2000) that is the 64th since the last line mark sets `chr_spr_sel_o` to 1 (sprite set). The 81st such read sets it to 0 (background set).
- R11: While the tall-sprite flag is clear, pattern-table reads leave `chr_spr_sel_o` unchanged.
- R12: After reset, `irq_o` is 0, the status read gives 0x00 and `chr_spr_sel_o` is 0. The stored previous address is 0x3FFF, so no first read can match it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all state updates on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ce | input | 1 | One-cycle strobe marking each CPU cycle, used for bus-idle timing |
| ppu_rd | input | 1 | Video processor read strobe, one read per asserted cycle |
| ppu_addr | input | 14 | Video processor read address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Status byte during a read of 0x5204, else 0 |
| irq_o | output | 1 | Interrupt request, pending AND enable |
| chr_spr_sel_o | output | 1 | Pattern bank set select: 1 for sprite, 0 for background |

## Verification
The hardest states to reach are the ones where the match count sits next to a boundary. One such state is a fourth or sixth repeat of an address that has already marked a line. Another is a run that is broken by a different nametable address just before the third read. To reach these, the bench issues exact read sequences and then changes the target between runs. A second mark that should not happen would then show up as a set pending bit. Bus-idle exit is hard to reach because the read that marked the last line shields the first CPU cycle that follows it. The bench therefore steps `cpu_ce` one strobe at a time and reads the in-frame bit after each strobe.

// File: rtl/scan_snoop_pkg.sv
package scan_snoop_pkg;
    localparam int PPU_AW = 14;
    localparam int CPU_AW = 16;
    localparam int DW     = 8;

    localparam logic [CPU_AW-1:0] A_PPUCTRL = 16'h2000;
    localparam logic [CPU_AW-1:0] A_PPUMASK = 16'h2001;
    localparam logic [CPU_AW-1:0] A_TARGET  = 16'h5203;
    localparam logic [CPU_AW-1:0] A_STATUS  = 16'h5204;
    localparam logic [CPU_AW-1:0] A_VEC_LO  = 16'hFFFA;

    localparam logic [PPU_AW-1:0] NT_FIRST = 14'h2000;
    localparam logic [PPU_AW-1:0] NT_LAST  = 14'h3EFF;
    localparam logic [PPU_AW-1:0] PREV_RST = 14'h3FFF;
    localparam logic [PPU_AW-1:0] PREV_CLR = 14'h0000;
    localparam logic [9:0]        ATTR_OFS = 10'h3C0;

    typedef enum logic [1:0] {
        MC_NONE,
        MC_ONE,
        MC_TWO,
        MC_MORE
    } match_e;

    function automatic logic in_nt(input logic [PPU_AW-1:0] a);
        return (a >= NT_FIRST) && (a <= NT_LAST);
    endfunction

    function automatic logic in_attr(input logic [PPU_AW-1:0] a);
        return a[9:0] >= ATTR_OFS;
    endfunction

    function automatic logic in_pattern(input logic [PPU_AW-1:0] a);
        return a < NT_FIRST;
    endfunction
endpackage

// File: rtl/scan_match.sv
module scan_match
    import scan_snoop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [PPU_AW-1:0] addr,
    input  logic              clr,
    output logic              line_o
);
    typedef struct packed {
        logic [PPU_AW-1:0] prev;
        match_e            cnt;
    } mstate_t;

    mstate_t st_d, st_q;
    logic    nt_rd, same;

    always_comb begin
        nt_rd  = rd && in_nt(addr);
        same   = nt_rd && !in_attr(addr) && (addr == st_q.prev);
        line_o = same && (st_q.cnt == MC_ONE) && !clr;
        st_d   = st_q;
        if (clr) begin
            st_d.prev = PREV_CLR;
            st_d.cnt  = MC_NONE;
        end else if (nt_rd) begin
            st_d.prev = addr;
            if (same) begin
                case (st_q.cnt)
                    MC_NONE: st_d.cnt = MC_ONE;
                    MC_ONE:  st_d.cnt = MC_TWO;
                    default: st_d.cnt = MC_MORE;
                endcase
            end else begin
                st_d.cnt = MC_NONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.prev <= PREV_RST;
            st_q.cnt  <= MC_NONE;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/scan_idle.sv
module scan_idle #(
    parameter int IDLE_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic rd,
    output logic timeout_o
);
    localparam int IDLE_W = $clog2(IDLE_LIMIT + 1);
    localparam logic [IDLE_W-1:0] LAST = IDLE_W'(IDLE_LIMIT - 1);

    typedef struct packed {
        logic              seen;
        logic [IDLE_W-1:0] idle;
    } istate_t;

    istate_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        timeout_o = 1'b0;
        if (ce) begin
            st_d.seen = 1'b0;
            if (st_q.seen || rd) begin
                st_d.idle = '0;
            end else if (st_q.idle == LAST) begin
                st_d.idle = '0;
                timeout_o = 1'b1;
            end else begin
                st_d.idle = st_q.idle + 1'b1;
            end
        end else if (rd) begin
            st_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/scan_fetch.sv
module scan_fetch
    import scan_snoop_pkg::*;
#(
    parameter int FETCH_W   = 8,
    parameter int SPR_START = 64,
    parameter int SPR_END   = 81
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line,
    input  logic              rd,
    input  logic [PPU_AW-1:0] addr,
    input  logic              tall,
    output logic              spr_sel_o
);
    localparam logic [FETCH_W-1:0] CNT_MAX = '1;
    localparam logic [FETCH_W-1:0] AT_SPR  = FETCH_W'(SPR_START);
    localparam logic [FETCH_W-1:0] AT_BG   = FETCH_W'(SPR_END);

    typedef struct packed {
        logic [FETCH_W-1:0] cnt;
        logic               sel;
    } fstate_t;

    fstate_t            st_d, st_q;
    logic [FETCH_W-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        cnt_inc = (st_q.cnt == CNT_MAX) ? st_q.cnt : st_q.cnt + 1'b1;
        if (line) begin
            st_d.cnt = '0;
        end else if (rd && in_pattern(addr)) begin
            st_d.cnt = cnt_inc;
            if (tall && cnt_inc == AT_SPR) st_d.sel = 1'b1;
            if (tall && cnt_inc == AT_BG)  st_d.sel = 1'b0;
        end
    end

    assign spr_sel_o = st_q.sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/scan_snoop_top.sv
module scan_snoop_top
    import scan_snoop_pkg::*;
#(
    parameter int LINE_W     = 9,
    parameter int FETCH_W    = 8,
    parameter int SPR_START  = 64,
    parameter int SPR_END    = 81,
    parameter int IDLE_LIMIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_ce,
    input  logic              ppu_rd,
    input  logic [PPU_AW-1:0] ppu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     cpu_rdata,
    output logic              irq_o,
    output logic              chr_spr_sel_o
);
    typedef struct packed {
        logic              in_frame;
        logic [LINE_W-1:0] line_cnt;
        logic [DW-1:0]     target;
        logic              pending;
        logic              irq_en;
        logic              tall;
    } tstate_t;

    tstate_t           st_d, st_q;
    logic              line_tick, idle_to, vec_rd, mask_off, stat_rd, frame_exit;
    logic [LINE_W-1:0] cnt_next;

    logic              in_frame_w, pending_w, irq_en_w;
    logic [LINE_W-1:0] line_cnt_w;

    assign vec_rd     = cpu_rd && (cpu_addr[CPU_AW-1:1] == A_VEC_LO[CPU_AW-1:1]);
    assign mask_off   = cpu_wr && (cpu_addr == A_PPUMASK) && (cpu_wdata[4:3] == 2'b00);
    assign stat_rd    = cpu_rd && (cpu_addr == A_STATUS);
    assign frame_exit = vec_rd || mask_off || idle_to;

    scan_match u_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (ppu_rd),
        .addr   (ppu_addr),
        .clr    (frame_exit),
        .line_o (line_tick)
    );

    scan_idle #(.IDLE_LIMIT(IDLE_LIMIT)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (cpu_ce),
        .rd        (ppu_rd),
        .timeout_o (idle_to)
    );

    scan_fetch #(
        .FETCH_W  (FETCH_W),
        .SPR_START(SPR_START),
        .SPR_END  (SPR_END)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .line      (line_tick),
        .rd        (ppu_rd),
        .addr      (ppu_addr),
        .tall      (st_q.tall),
        .spr_sel_o (chr_spr_sel_o)
    );

    always_comb begin
        st_d     = st_q;
        cnt_next = st_q.line_cnt + 1'b1;
        if (stat_rd) st_d.pending = 1'b0;
        if (frame_exit) begin
            st_d.in_frame = 1'b0;
        end else if (line_tick) begin
            if (!st_q.in_frame) begin
                st_d.in_frame = 1'b1;
                st_d.line_cnt = '0;
            end else begin
                st_d.line_cnt = cnt_next;
                if (cnt_next == LINE_W'(st_q.target)) st_d.pending = 1'b1;
            end
        end
        if (cpu_wr) begin
            case (cpu_addr)
                A_TARGET:  st_d.target = cpu_wdata;
                A_STATUS:  st_d.irq_en = cpu_wdata[7];
                A_PPUCTRL: st_d.tall   = cpu_wdata[5];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_rdata  = stat_rd ? {st_q.pending, st_q.in_frame, {(DW-2){1'b0}}} : '0;
    assign irq_o      = st_q.pending && st_q.irq_en;
    assign in_frame_w = st_q.in_frame;
    assign pending_w  = st_q.pending;
    assign irq_en_w   = st_q.irq_en;
    assign line_cnt_w = st_q.line_cnt;
endmodule

// File: rtl/scan_snoop_chk.sv
module scan_snoop_chk
    import scan_snoop_pkg::*;
#(
    parameter int LINE_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic [DW-1:0]     cpu_wdata,
    input logic              ppu_rd,
    input logic [PPU_AW-1:0] ppu_addr,
    input logic              irq_o,
    input logic              chr_sel,
    input logic              line_tick,
    input logic              idle_to,
    input logic              in_frame,
    input logic              pending,
    input logic [LINE_W-1:0] line_cnt
);
    // R1
    line_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_tick |-> (ppu_rd && in_nt(ppu_addr) && !in_attr(ppu_addr)));

    // R3
    entry_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame) |-> (line_cnt == '0));

    // R3
    pend_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(in_frame));

    // R5
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr == A_STATUS && !line_tick) |=> !pending);

    // R6
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == A_STATUS && !cpu_wdata[7]) |=> !irq_o);

    // R7
    vec_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && (cpu_addr == 16'hFFFA || cpu_addr == 16'hFFFB)) |=> !in_frame);

    // R9
    idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_to |=> !in_frame);

    // R10
    sel_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chr_sel) |-> $past(ppu_rd && in_pattern(ppu_addr)));
endmodule

bind scan_snoop_top scan_snoop_chk #(.LINE_W(LINE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_rd   (cpu_rd),
    .cpu_wr   (cpu_wr),
    .cpu_addr (cpu_addr),
    .cpu_wdata(cpu_wdata),
    .ppu_rd   (ppu_rd),
    .ppu_addr (ppu_addr),
    .irq_o    (irq_o),
    .chr_sel  (chr_spr_sel_o),
    .line_tick(line_tick),
    .idle_to  (idle_to),
    .in_frame (in_frame_w),
    .pending  (pending_w),
    .line_cnt (line_cnt_w)
);

// File: tb/scan_snoop_top_tb.sv
module scan_snoop_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_ce = 1'b0;
    logic        ppu_rd = 1'b0;
    logic [13:0] ppu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        irq_o;
    logic        chr_spr_sel_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    scan_snoop_top u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .ppu_rd(ppu_rd), .ppu_addr(ppu_addr),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .irq_o(irq_o), .chr_spr_sel_o(chr_spr_sel_o)
    );

    localparam logic [2:0] OP_WR = 3'd0, OP_LINE = 3'd1, OP_RDS = 3'd2, OP_VEC = 3'd3, OP_IDLE = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] addr;
        logic [7:0]  data;
        logic        irq;
        logic [7:0]  stat;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [0:NV-1] = '{
        '{OP_WR,   16'h5204, 8'h80, 1'b0, 8'h00},
        '{OP_WR,   16'h5203, 8'h02, 1'b0, 8'h00},
        '{OP_WR,   16'h2001, 8'h18, 1'b0, 8'h00},
        '{OP_LINE, 16'h2000, 8'h00, 1'b0, 8'h00},
        '{OP_RDS,  16'h5204, 8'h00, 1'b0, 8'h40},
        '{OP_LINE, 16'h2021, 8'h00, 1'b0, 8'h00},
        '{OP_LINE, 16'h2042, 8'h00, 1'b1, 8'h00},
        '{OP_RDS,  16'h5204, 8'h00, 1'b0, 8'hC0},
        '{OP_RDS,  16'h5204, 8'h00, 1'b0, 8'h40},
        '{OP_LINE, 16'h2063, 8'h00, 1'b0, 8'h00},
        '{OP_VEC,  16'hFFFA, 8'h00, 1'b0, 8'h00},
        '{OP_RDS,  16'h5204, 8'h00, 1'b0, 8'h00},
        '{OP_LINE, 16'h2000, 8'h00, 1'b0, 8'h00},
        '{OP_LINE, 16'h2021, 8'h00, 1'b0, 8'h00},
        '{OP_LINE, 16'h2042, 8'h00, 1'b1, 8'h00},
        '{OP_WR,   16'h5204, 8'h00, 1'b0, 8'h00},
        '{OP_RDS,  16'h5204, 8'h00, 1'b0, 8'hC0},
        '{OP_WR,   16'h5204, 8'h80, 1'b0, 8'h00},
        '{OP_IDLE, 16'h0000, 8'h00, 1'b0, 8'h00},
        '{OP_RDS,  16'h5204, 8'h00, 1'b0, 8'h00}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic ppu_read(input logic [13:0] a);
        ppu_rd = 1'b1; ppu_addr = a;
        @(posedge clk); @(negedge clk);
        ppu_rd = 1'b0;
    endtask

    task automatic line3(input logic [13:0] a);
        for (int i = 0; i < 3; i++) ppu_read(a);
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(posedge clk); @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [15:0] a, output logic [7:0] d);
        cpu_rd = 1'b1; cpu_addr = a;
        #1 d = cpu_rdata;
        @(posedge clk); @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic stat(input string tag, input logic [7:0] exp);
        logic [7:0] d;
        cpu_read(16'h5204, d);
        check(tag, d, exp);
    endtask

    task automatic ce_pulse(input int n);
        for (int i = 0; i < n; i++) begin
            cpu_ce = 1'b1;
            @(posedge clk); @(negedge clk);
            cpu_ce = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 irq", irq_o, 0);
        check("R12 sel", chr_spr_sel_o, 0);
        stat("R12 status", 8'h00);

        // Table walk: R3 R5 R6 R7 R9
        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                OP_WR:   cpu_write(VECS[i].addr, VECS[i].data);
                OP_LINE: line3(VECS[i].addr[13:0]);
                OP_RDS:  stat($sformatf("R5 table row %0d status", i), VECS[i].stat);
                OP_VEC:  cpu_read(VECS[i].addr, d);
                default: ce_pulse(4);
            endcase
            check($sformatf("R3 R6 table row %0d irq", i), irq_o, VECS[i].irq);
        end

        // R1 broken run: A A B B stays out, third B enters
        ppu_read(14'h2100); ppu_read(14'h2100);
        ppu_read(14'h2104); ppu_read(14'h2104);
        stat("R1 broken run", 8'h00);
        ppu_read(14'h2104);
        stat("R1 third repeat", 8'h40);
        cpu_read(16'hFFFB, d);
        stat("R7 vector FFFB", 8'h00);

        // R2 attribute repeats never mark
        for (int i = 0; i < 4; i++) ppu_read(14'h23C0);
        stat("R2 attribute", 8'h00);

        // R1 long run marks only once
        line3(14'h2000);
        cpu_write(16'h5203, 8'h01);
        line3(14'h2200);
        stat("R1 first mark", 8'hC0);
        cpu_write(16'h5203, 8'h02);
        line3(14'h2200);
        stat("R1 no remark", 8'h40);
        cpu_read(16'hFFFA, d);

        // R4 target zero
        cpu_write(16'h5203, 8'h00);
        line3(14'h2000);
        for (int i = 1; i < 6; i++) line3(14'h2000 + 14'(i));
        check("R4 irq", irq_o, 0);
        stat("R4 status", 8'h40);

        // R8 mask writes
        cpu_write(16'h2001, 8'h08);
        stat("R8 render on kept", 8'h40);
        cpu_write(16'h2001, 8'hE7);
        stat("R8 render off exit", 8'h00);

        // R9 idle timing
        line3(14'h2000);
        ce_pulse(1);
        ce_pulse(2);
        stat("R9 two idle", 8'h40);
        ce_pulse(1);
        stat("R9 three idle", 8'h00);

        // R5 other address reads zero
        cpu_read(16'h5203, d);
        check("R5 other addr", d, 0);

        // R10 tall sprite switching
        cpu_write(16'h2000, 8'h20);
        line3(14'h2000);
        for (int i = 0; i < 63; i++) ppu_read(14'h0100);
        check("R10 before 64", chr_spr_sel_o, 0);
        ppu_read(14'h0100);
        check("R10 at 64", chr_spr_sel_o, 1);
        for (int i = 0; i < 16; i++) ppu_read(14'h1100);
        check("R10 at 80", chr_spr_sel_o, 1);
        ppu_read(14'h1100);
        check("R10 at 81", chr_spr_sel_o, 0);
        line3(14'h2020);
        for (int i = 0; i < 64; i++) ppu_read(14'h0200);
        check("R10 next line", chr_spr_sel_o, 1);

        // R11 flag cleared: selection held
        cpu_write(16'h2000, 8'h00);
        line3(14'h2040);
        for (int i = 0; i < 81; i++) ppu_read(14'h0300);
        check("R11 held", chr_spr_sel_o, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule